// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two `WIDTH`-bit operands over several clock cycles and leaves the `2*WIDTH`-bit product in a pair of registers: a high half and a low half. It retires one bit of the multiplier per cycle. When the current multiplier bit is one, the multiplicand is added into the high half. The sum is then shifted right by one place. The adder's carry (unsigned) or the extended sign (signed) drops into the top of the high half. The bit shifted out of the high half enters the top of the low half. The low half starts out holding the multiplier, so its least significant bit is always the multiplier bit for the current step.

A single-cycle `start_i` pulse in the idle state captures `x_i`, `y_i` and `signed_i`. In unsigned mode, every step that adds uses zero extension. In two's-complement mode, every partial sum is sign-extended during the shift. The final step subtracts the multiplicand instead of adding it, because the top multiplier bit carries negative weight. `done_o` pulses for one cycle when the product is ready. The product then stays on `hi_o`/`lo_o` until the next accepted start.

The controller is a three-state machine:
- **IDLE**: waiting. The transition *accept* (start seen) goes to RUN and loads the operands.
- **RUN**: one step per cycle while a down-counter runs from `WIDTH` to 1. The transition *finish* (counter at 1) goes to DONE.
- **DONE**: pulses `done_o`. The transition *retire* always returns to IDLE.

Top module: `seq_mult`

## Requirements
- R1: While reset is asserted and right after it, `busy_o` and `done_o` are 0 and `hi_o` and `lo_o` are all zeros.
- R2: A start seen at a rising edge in the idle state loads the operands. After that edge, `hi_o` is 0, `lo_o` equals the captured `y_i` and `busy_o` is 1.
- R3: With `signed_i`=0 at start, `{hi_o, lo_o}` at done equals the unsigned product of the captured operands.
- R4: With `signed_i`=1 at start, `{hi_o, lo_o}` at done equals the two's-complement product of the captured operands.
- R5: `done_o` is high for exactly one cycle, beginning at the `WIDTH`-th rising edge after the edge that accepted start. `busy_o` is high from the accepting edge through the done cycle and low in the cycle after.
- R6: `start_i` and the operand inputs are ignored while `busy_o` is 1, including the done cycle. The product and the done timing are unchanged.
- R7: While idle without start, `hi_o` and `lo_o` hold their values.
- R8: When the product fits in `WIDTH` bits, `hi_o` is all zeros in unsigned mode. In signed mode it is all copies of `lo_o`'s top bit.
- R9: In unsigned mode, the adder carry enters the top of the high half. All-ones times all-ones gives `hi_o` = all ones except bit 0, and `lo_o` = 1.
- R10: In signed mode, the last step subtracts. Most-negative times most-negative gives `2^(2*WIDTH-2)`. Most-negative times 1 gives the sign-extended most-negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a multiplication (accepted only when idle) |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| x_i | input | WIDTH | Multiplicand |
| y_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | High from acceptance through the done cycle |
| done_o | output | 1 | One-cycle pulse, product valid |
| hi_o | output | WIDTH | Upper half of the product |
| lo_o | output | WIDTH | Lower half of the product |

## Verification
Unsigned runs use several multiplier patterns:
- a zero operand and a multiplier of 1, which separate the shift path from the add path;
- small values and alternating bit patterns, which show whether bits are dropped or mis-ordered between the two halves;
- all-ones squared, which only comes out right if the adder carry is shifted into the top of the high half.

Signed runs use mixed-sign and negative-negative pairs, and the most-negative value as multiplier. These show whether the partial sums are sign-extended and whether the final step subtracts. Small products in both modes check the upper-half fill. A run with start and random operands driven throughout the busy window, and at done, shows that nothing is re-captured.

// File: rtl/mult_pkg.sv
package mult_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mult_state_e;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } mult_op_e;

endpackage

// File: rtl/mult_ctrl.sv
module mult_ctrl
    import mult_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      signed_i,
    input  logic      ybit_i,
    output logic      load_o,
    output logic      step_o,
    output mult_op_e  op_o,
    output logic      busy_o,
    output logic      done_o
);

    localparam int CW = $clog2(WIDTH + 1);

    mult_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          sgn_q;
    logic          last_step;

    assign last_step = (cnt_q == CW'(1));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_RUN;   // accept
            ST_RUN:  if (last_step) state_d = ST_DONE;  // finish
            ST_DONE:                state_d = ST_IDLE;  // retire
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register, iteration counter and captured mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sgn_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                cnt_q <= CW'(WIDTH);
                sgn_q <= signed_i;
            end else if (state_q == ST_RUN) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // outputs per state
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        op_o   = OP_PASS;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = start_i;
            end
            ST_RUN: begin
                busy_o = 1'b1;
                step_o = 1'b1;
                if (ybit_i)
                    op_o = (sgn_q && last_step) ? OP_SUB : OP_ADD;
            end
            ST_DONE: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mult_addsub.sv
module mult_addsub
    import mult_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] hi_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic             sgn_i,
    input  mult_op_e         op_i,
    output logic [WIDTH:0]   sum_o
);

    localparam int EW = WIDTH + 1;

    logic [EW-1:0] hi_ext;
    logic [EW-1:0] x_ext;

    // one extra bit: carry for unsigned, sign for two's complement
    assign hi_ext = {sgn_i & hi_i[WIDTH-1], hi_i};
    assign x_ext  = {sgn_i & x_i[WIDTH-1],  x_i};

    always_comb begin
        unique case (op_i)
            OP_ADD:  sum_o = hi_ext + x_ext;
            OP_SUB:  sum_o = hi_ext - x_ext;
            default: sum_o = hi_ext;
        endcase
    end

endmodule

// File: rtl/mult_regs.sv
module mult_regs #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic [WIDTH:0]   sum_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o,
    output logic [WIDTH-1:0] x_o,
    output logic             sgn_o
);

    logic [WIDTH-1:0] hi_q, lo_q, x_q;
    logic             sgn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            x_q   <= '0;
            sgn_q <= 1'b0;
        end else if (load_i) begin
            hi_q  <= '0;
            lo_q  <= y_i;
            x_q   <= x_i;
            sgn_q <= signed_i;
        end else if (step_i) begin
            // right shift of the extended sum: its top bit enters Hi,
            // its bottom bit enters Lo, used multiplier bit leaves Lo
            hi_q <= sum_i[WIDTH:1];
            lo_q <= {sum_i[0], lo_q[WIDTH-1:1]};
        end
    end

    assign hi_o  = hi_q;
    assign lo_o  = lo_q;
    assign x_o   = x_q;
    assign sgn_o = sgn_q;

endmodule

// File: rtl/seq_mult.sv
module seq_mult
    import mult_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);

    logic             load, step;
    mult_op_e         op;
    logic [WIDTH:0]   sum;
    logic [WIDTH-1:0] hi_q, lo_q, x_q;
    logic             sgn_q;

    mult_ctrl #(.WIDTH(WIDTH)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .signed_i (signed_i),
        .ybit_i   (lo_q[0]),
        .load_o   (load),
        .step_o   (step),
        .op_o     (op),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    mult_addsub #(.WIDTH(WIDTH)) addsub_i (
        .hi_i  (hi_q),
        .x_i   (x_q),
        .sgn_i (sgn_q),
        .op_i  (op),
        .sum_o (sum)
    );

    mult_regs #(.WIDTH(WIDTH)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .signed_i (signed_i),
        .x_i      (x_i),
        .y_i      (y_i),
        .sum_i    (sum),
        .hi_o     (hi_q),
        .lo_o     (lo_q),
        .x_o      (x_q),
        .sgn_o    (sgn_q)
    );

    assign hi_o = hi_q;
    assign lo_o = lo_q;

endmodule

// File: rtl/seq_mult_chk.sv
module seq_mult_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             signed_i,
    input logic [WIDTH-1:0] x_i,
    input logic [WIDTH-1:0] y_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o
);

    localparam int PW = 2 * WIDTH;

    logic [31:0]   run_cnt;
    logic [PW-1:0] exp_q;
    logic [PW-1:0] xe, ye;

    assign xe = signed_i ? {{WIDTH{x_i[WIDTH-1]}}, x_i} : {{WIDTH{1'b0}}, x_i};
    assign ye = signed_i ? {{WIDTH{y_i[WIDTH-1]}}, y_i} : {{WIDTH{1'b0}}, y_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            exp_q   <= '0;
        end else if (!busy_o && start_i) begin
            run_cnt <= '0;
            exp_q   <= xe * ye;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 32'd1;
        end
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && hi_o == '0 && lo_o == $past(y_i)));

    // R3 R4
    product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ({hi_o, lo_o} == exp_q));

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == 32'(WIDTH)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(hi_o) && $stable(lo_o)));

endmodule

bind seq_mult seq_mult_chk #(.WIDTH(WIDTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .signed_i (signed_i),
    .x_i      (x_i),
    .y_i      (y_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
);

// File: tb/seq_mult_tb_top.sv
`timescale 1ns/1ps
module seq_mult_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] x_i = '0;
    logic [W-1:0] y_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] hi_o, lo_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    seq_mult #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .x_i(x_i), .y_i(y_i), .busy_o(busy_o), .done_o(done_o),
        .hi_o(hi_o), .lo_o(lo_o)
    );

    function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a,
                                                input logic [W-1:0] b,
                                                input logic s);
        logic [2*W-1:0] ae, be;
        ae = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        be = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        return ae * be;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // start a product; on return the done cycle is being observed
    task automatic do_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic s, input bit noisy);
        int cyc;
        @(negedge clk);
        start_i = 1'b1; x_i = a; y_i = b; signed_i = s;
        @(negedge clk);
        start_i = 1'b0;
        // R2: loaded after the accepting edge
        chk(busy_o && hi_o == '0 && lo_o == b, "R2 load",
            {hi_o, lo_o}, {{W{1'b0}}, b});
        cyc = 0;
        while (!done_o && cyc < 200) begin
            if (noisy) begin
                start_i = 1'b1; x_i = $urandom; y_i = $urandom; signed_i = ~s;
            end
            @(negedge clk);
            cyc++;
        end
        // R5: done at the WIDTH-th edge after acceptance
        chk(cyc == W, "R5 latency", 64'(cyc), 64'(W));
        chk({hi_o, lo_o} == ref_prod(a, b, s), s ? "R4 signed product" : "R3 unsigned product",
            {hi_o, lo_o}, ref_prod(a, b, s));
        if (noisy) begin
            // R6: start presented in the done cycle too
            start_i = 1'b1; x_i = $urandom; y_i = $urandom;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(!done_o && !busy_o, "R5 single pulse", {62'd0, done_o, busy_o}, 64'd0);
    endtask

    task automatic t_reset;
        #1;
        chk(!busy_o && !done_o && hi_o == '0 && lo_o == '0, "R1 reset",
            {hi_o, lo_o}, 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && hi_o == '0 && lo_o == '0, "R1 after reset",
            {hi_o, lo_o}, 64'd0);
    endtask

    task automatic t_unsigned;
        do_mult(32'd0, 32'hDEADBEEF, 1'b0, 1'b0);
        do_mult(32'h12345678, 32'd1, 1'b0, 1'b0);
        do_mult(32'd3, 32'd5, 1'b0, 1'b0);
        // R8: unsigned fit leaves Hi zero
        chk(hi_o == '0 && lo_o == 32'd15, "R8 unsigned fit", {hi_o, lo_o}, 64'd15);
        do_mult(32'hAAAAAAAA, 32'h55555555, 1'b0, 1'b0);
        do_mult(32'h80000001, 32'hFFFF0000, 1'b0, 1'b0);
    endtask

    task automatic t_carry;
        do_mult('1, '1, 1'b0, 1'b0);
        // R9: all-ones squared
        chk(hi_o == 32'hFFFFFFFE && lo_o == 32'd1, "R9 carry into Hi",
            {hi_o, lo_o}, 64'hFFFFFFFE_00000001);
    endtask

    task automatic t_signed;
        do_mult(-32'sd3, 32'd5, 1'b1, 1'b0);
        // R8: negative result that fits: Hi copies Lo's sign
        chk(hi_o == '1 && lo_o[W-1], "R8 signed fit", {hi_o, lo_o}, {32'hFFFFFFFF, -32'sd15});
        do_mult(32'd7, -32'sd9, 1'b1, 1'b0);
        do_mult(-32'sd6, -32'sd11, 1'b1, 1'b0);
        chk(hi_o == '0 && lo_o == 32'd66, "R8 signed fit positive", {hi_o, lo_o}, 64'd66);
        do_mult(32'h7FFFFFFF, 32'h80000000, 1'b1, 1'b0);
    endtask

    task automatic t_most_negative;
        do_mult(32'h80000000, 32'h80000000, 1'b1, 1'b0);
        // R10: last step subtracts
        chk({hi_o, lo_o} == 64'h4000000000000000, "R10 min*min",
            {hi_o, lo_o}, 64'h4000000000000000);
        do_mult(32'h80000000, 32'd1, 1'b1, 1'b0);
        chk({hi_o, lo_o} == 64'hFFFFFFFF80000000, "R10 min*1",
            {hi_o, lo_o}, 64'hFFFFFFFF80000000);
    endtask

    task automatic t_ignore_and_hold;
        logic [2*W-1:0] held;
        // R6: start and operands toggled throughout the busy window
        do_mult(32'h0F0F1234, -32'sd77, 1'b1, 1'b1);
        held = {hi_o, lo_o};
        chk(held == ref_prod(32'h0F0F1234, -32'sd77, 1'b1), "R6 start ignored",
            held, ref_prod(32'h0F0F1234, -32'sd77, 1'b1));
        x_i = $urandom; y_i = $urandom;
        repeat (4) @(negedge clk);
        // R7: idle without start keeps the product
        chk({hi_o, lo_o} == held && !busy_o, "R7 hold", {hi_o, lo_o}, held);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_unsigned();
        t_carry();
        t_signed();
        t_most_negative();
        t_ignore_and_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule